// File: doc/BRIEF.md
# AUX Channel Native Transaction Engine

This block carries out native read and write transactions on a DisplayPort AUX channel, addressed into the sink's 20-bit configuration space. A requester supplies an address, a byte count, a direction and up to sixteen bytes of write data through a single-cycle command handshake. The engine latches the command and clamps the count to the sixteen-byte buffer. It builds the request command word and presents the address to the PHY side as three fields. It then raises an enable bit that the PHY is expected to clear once the request has gone out.

After the enable bit clears, the engine waits for a reply flag, which it acknowledges at once. It checks the reply's error flag and status field. An attempt that times out or comes back with an error is repeated from a freshly cleared buffer, up to a fixed number of attempts. The requester then sees a one-cycle done pulse, an error bit and, for reads, the returned bytes.

Both waits are measured in millisecond ticks. A parameterised prescaler derives these ticks from the system clock.

Top module: `aux_native_engine`

## Requirements
- R1: The effective byte count is the requested count limited to the range 1..16 (0 becomes 1, anything above 16 becomes 16). Command word bits 7:4 carry the effective count minus one.
- R2: A transfer is attempted at most MAX_TRIES times (one rising edge of phy_en per attempt). When every attempt fails, done is accompanied by err=1. When any attempt succeeds, no further attempt is made and err=0.
- R3: While phy_en is high, phy_addr_lo, phy_addr_mid and phy_addr_hi hold address bits 7:0, 15:8 and 19:16 of the command, and phy_cmd stays stable.
- R4: Command word bit 3 is always 1 (native transaction). Bits 2:0 are 000 for a write and 001 for a read.
- R5: For a write, phy_wdata byte i (bits 8i+7:8i) equals command byte i for i below the effective count. All higher bytes are zero because the buffer is cleared at the start of every attempt.
- R6: After a successful read, rsp_rdata byte i equals phy_rdata byte i at the reply for i below the effective count. All higher bytes are zero.
- R7: An attempt fails if phy_en_clr does not arrive within EN_TMO_MS ticks after phy_en rises. It also fails if phy_reply does not arrive within RPLY_TMO_MS ticks after the clear. One tick is TICK_DIV clock cycles, and each wait restarts the prescaler.
- R8: Each reply observed while waiting produces exactly one one-cycle pulse on phy_flag_clr in the following cycle.
- R9: A reply that carries phy_err=1 or a non-zero phy_status fails the attempt.
- R10: cmd_ready is high only while idle, and cmd_valid is ignored otherwise. done is a single-cycle pulse per accepted command, and phy_en is never high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle, command accepted when cmd_valid is high |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 20 | Configuration-space address |
| cmd_len | input | LEN_W | Requested byte count |
| cmd_wdata | input | 128 | Write payload, byte i in bits 8i+7:8i |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Transfer failed after all attempts |
| rsp_rdata | output | 128 | Read data / buffer contents |
| phy_en | output | 1 | Transaction enable bit towards the PHY |
| phy_addr_lo | output | 8 | Address bits 7:0 |
| phy_addr_mid | output | 8 | Address bits 15:8 |
| phy_addr_hi | output | 4 | Address bits 19:16 |
| phy_cmd | output | 8 | Request command word |
| phy_wdata | output | 128 | Data buffer contents sent with the request |
| phy_en_clr | input | 1 | PHY reports the enable bit self-cleared |
| phy_reply | input | 1 | Reply-received flag |
| phy_err | input | 1 | Access error flag, sampled with the reply |
| phy_status | input | 4 | AUX status field, sampled with the reply |
| phy_rdata | input | 128 | Reply data bytes |
| phy_flag_clr | output | 1 | Clears the reply and error flags |

## Verification
The bench builds the engine with TICK_DIV=5, EN_TMO_MS=20, RPLY_TMO_MS=10 and MAX_TRIES=10, so one tick lasts five cycles and the enable window is 100 cycles. With these values, a run in which all ten attempts time out completes in about a thousand cycles. That puts the retry limit, both timeout stages and slow-but-in-time PHY responses within reach of short directed tests. The default prescaler value is meant for real millisecond ticks, which a short run could never exhaust.

// File: rtl/aux_eng_pkg.sv
package aux_eng_pkg;

  localparam int BUF_BYTES = 16;
  localparam int BUF_W     = BUF_BYTES * 8;
  localparam int CNT_W     = $clog2(BUF_BYTES) + 1;
  localparam int ADDR_W    = 20;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_WAIT_EN,
    ST_WAIT_RPLY,
    ST_RESP
  } seq_state_t;

  // Limit a requested count to 1..BUF_BYTES.
  function automatic logic [CNT_W-1:0] clamp_len(input int unsigned n);
    if (n == 0) return CNT_W'(1);
    if (n > BUF_BYTES) return CNT_W'(BUF_BYTES);
    return CNT_W'(n);
  endfunction

  // Request word: count-1 on top, native flag, request code below.
  function automatic logic [7:0] build_cmd(input logic [CNT_W-1:0] n, input logic rd);
    logic [CNT_W-1:0] m;
    m = n - CNT_W'(1);
    return {m[3:0], 1'b1, 2'b00, rd};
  endfunction

  // One byte lane enabled for each counted byte.
  function automatic logic [BUF_W-1:0] byte_mask(input logic [CNT_W-1:0] n);
    logic [BUF_W-1:0] m;
    for (int i = 0; i < BUF_BYTES; i++)
      m[i*8 +: 8] = (i < int'(n)) ? 8'hFF : 8'h00;
    return m;
  endfunction

endpackage

// File: rtl/aux_ms_timer.sv
module aux_ms_timer #(
  parameter int TICK_DIV    = 50000,
  parameter int EN_TMO_MS   = 20,
  parameter int RPLY_TMO_MS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic sel_reply,
  output logic expired
);
  localparam int MAX_MS = (EN_TMO_MS > RPLY_TMO_MS) ? EN_TMO_MS : RPLY_TMO_MS;
  localparam int MS_W   = $clog2(MAX_MS + 1);
  localparam int PRE_W  = $clog2(TICK_DIV + 1);

  logic [PRE_W-1:0] pre_q;
  logic [MS_W-1:0]  ms_q;
  logic             tick;

  assign tick = (pre_q == PRE_W'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ms_q  <= '0;
    end else if (restart) begin
      pre_q <= '0;
      ms_q  <= '0;
    end else begin
      pre_q <= tick ? '0 : pre_q + PRE_W'(1);
      if (tick && ms_q != MS_W'(MAX_MS))
        ms_q <= ms_q + MS_W'(1);
    end
  end

  assign expired = sel_reply ? (ms_q >= MS_W'(RPLY_TMO_MS))
                             : (ms_q >= MS_W'(EN_TMO_MS));
endmodule

// File: rtl/aux_data_buf.sv
module aux_data_buf
  import aux_eng_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [BUF_W-1:0] cmd_wdata,
  input  logic             clr_load,
  input  logic             load_wr,
  input  logic             capture,
  input  logic [BUF_W-1:0] cap_data,
  input  logic [BUF_W-1:0] mask,
  output logic [BUF_W-1:0] buf_q
);
  logic [BUF_W-1:0] pay_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pay_q <= '0;
      buf_q <= '0;
    end else begin
      if (accept)
        pay_q <= cmd_wdata;
      if (clr_load)
        buf_q <= load_wr ? (pay_q & mask) : '0;
      else if (capture)
        buf_q <= cap_data & mask;
    end
  end
endmodule

// File: rtl/aux_seq_ctrl.sv
module aux_seq_ctrl
  import aux_eng_pkg::*;
#(
  parameter int LEN_W     = 8,
  parameter int MAX_TRIES = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              phy_en_clr,
  input  logic              phy_reply,
  input  logic              phy_err,
  input  logic [3:0]        phy_status,
  input  logic              tmo_expired,
  output logic              cmd_ready,
  output logic              done,
  output logic              err,
  output logic              phy_en,
  output logic              phy_flag_clr,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CNT_W-1:0]  len_q,
  output logic              rd_q,
  output logic              accept,
  output logic              attempt_start,
  output logic              capture,
  output logic              tmr_restart,
  output logic              tmr_sel_reply
);
  localparam int TRY_W = $clog2(MAX_TRIES + 1);

  seq_state_t       state_q;
  logic [TRY_W-1:0] tries_q;
  logic             reply_good;
  logic             attempt_fail;
  logic             last_try;

  assign cmd_ready     = (state_q == ST_IDLE);
  assign done          = (state_q == ST_RESP);
  assign accept        = cmd_ready && cmd_valid;
  assign attempt_start = (state_q == ST_PREP);
  assign reply_good    = !phy_err && (phy_status == 4'h0);
  assign capture       = (state_q == ST_WAIT_RPLY) && phy_reply && reply_good && rd_q;
  assign tmr_restart   = attempt_start || ((state_q == ST_WAIT_EN) && phy_en_clr);
  assign tmr_sel_reply = (state_q == ST_WAIT_RPLY);
  assign last_try      = (tries_q == TRY_W'(MAX_TRIES - 1));
  assign attempt_fail  = ((state_q == ST_WAIT_EN) && !phy_en_clr && tmo_expired) ||
                         ((state_q == ST_WAIT_RPLY) && phy_reply && !reply_good) ||
                         ((state_q == ST_WAIT_RPLY) && !phy_reply && tmo_expired);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      tries_q      <= '0;
      addr_q       <= '0;
      len_q        <= CNT_W'(1);
      rd_q         <= 1'b0;
      err          <= 1'b0;
      phy_en       <= 1'b0;
      phy_flag_clr <= 1'b0;
    end else begin
      phy_flag_clr <= 1'b0;
      if (attempt_fail) begin
        if (last_try) begin
          err     <= 1'b1;
          state_q <= ST_RESP;
        end else begin
          tries_q <= tries_q + TRY_W'(1);
          state_q <= ST_PREP;
        end
      end
      case (state_q)
        ST_IDLE: if (cmd_valid) begin
          addr_q  <= cmd_addr;
          len_q   <= clamp_len(int'(cmd_len));
          rd_q    <= !cmd_write;
          tries_q <= '0;
          err     <= 1'b0;
          state_q <= ST_PREP;
        end
        ST_PREP: begin
          phy_en  <= 1'b1;
          state_q <= ST_WAIT_EN;
        end
        ST_WAIT_EN: begin
          if (phy_en_clr) begin
            phy_en  <= 1'b0;
            state_q <= ST_WAIT_RPLY;
          end else if (tmo_expired) begin
            phy_en <= 1'b0;
          end
        end
        ST_WAIT_RPLY: if (phy_reply) begin
          phy_flag_clr <= 1'b1;
          if (reply_good) state_q <= ST_RESP;
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aux_native_engine.sv
module aux_native_engine
  import aux_eng_pkg::*;
#(
  parameter int TICK_DIV    = 50000,
  parameter int EN_TMO_MS   = 20,
  parameter int RPLY_TMO_MS = 10,
  parameter int MAX_TRIES   = 10,
  parameter int LEN_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [BUF_W-1:0]  cmd_wdata,
  output logic              done,
  output logic              err,
  output logic [BUF_W-1:0]  rsp_rdata,
  output logic              phy_en,
  output logic [7:0]        phy_addr_lo,
  output logic [7:0]        phy_addr_mid,
  output logic [3:0]        phy_addr_hi,
  output logic [7:0]        phy_cmd,
  output logic [BUF_W-1:0]  phy_wdata,
  input  logic              phy_en_clr,
  input  logic              phy_reply,
  input  logic              phy_err,
  input  logic [3:0]        phy_status,
  input  logic [BUF_W-1:0]  phy_rdata,
  output logic              phy_flag_clr
);
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  len_q;
  logic              rd_q;
  logic              accept;
  logic              attempt_start;
  logic              capture;
  logic              tmr_restart;
  logic              tmr_sel_reply;
  logic              tmo_expired;
  logic [BUF_W-1:0]  lane_mask;
  logic [BUF_W-1:0]  buf_q;

  aux_seq_ctrl #(.LEN_W(LEN_W), .MAX_TRIES(MAX_TRIES)) i_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .phy_en_clr(phy_en_clr), .phy_reply(phy_reply), .phy_err(phy_err), .phy_status(phy_status),
    .tmo_expired(tmo_expired),
    .cmd_ready(cmd_ready), .done(done), .err(err), .phy_en(phy_en), .phy_flag_clr(phy_flag_clr),
    .addr_q(addr_q), .len_q(len_q), .rd_q(rd_q), .accept(accept),
    .attempt_start(attempt_start), .capture(capture),
    .tmr_restart(tmr_restart), .tmr_sel_reply(tmr_sel_reply)
  );

  aux_ms_timer #(.TICK_DIV(TICK_DIV), .EN_TMO_MS(EN_TMO_MS), .RPLY_TMO_MS(RPLY_TMO_MS)) i_tmr (
    .clk(clk), .rst_n(rst_n), .restart(tmr_restart), .sel_reply(tmr_sel_reply),
    .expired(tmo_expired)
  );

  assign lane_mask = byte_mask(len_q);

  aux_data_buf i_buf (
    .clk(clk), .rst_n(rst_n), .accept(accept), .cmd_wdata(cmd_wdata),
    .clr_load(attempt_start), .load_wr(!rd_q), .capture(capture),
    .cap_data(phy_rdata), .mask(lane_mask), .buf_q(buf_q)
  );

  assign phy_addr_lo  = addr_q[7:0];
  assign phy_addr_mid = addr_q[15:8];
  assign phy_addr_hi  = addr_q[19:16];
  assign phy_cmd      = build_cmd(len_q, rd_q);
  assign phy_wdata    = buf_q;
  assign rsp_rdata    = buf_q;
endmodule

// File: rtl/aux_engine_checker.sv
module aux_engine_checker #(
  parameter int EN_WIN    = 100,
  parameter int MAX_TRIES = 10
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_ready,
  input logic        done,
  input logic        phy_en,
  input logic [7:0]  phy_addr_lo,
  input logic [7:0]  phy_addr_mid,
  input logic [3:0]  phy_addr_hi,
  input logic [7:0]  phy_cmd,
  input logic        phy_reply,
  input logic        phy_flag_clr,
  input logic        attempt_start
);
  int   rise_cnt;
  int   en_run;
  logic en_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_cnt <= 0;
      en_run   <= 0;
      en_d     <= 1'b0;
    end else begin
      en_d     <= phy_en;
      en_run   <= phy_en ? en_run + 1 : 0;
      if (cmd_ready) rise_cnt <= 0;
      else if (phy_en && !en_d) rise_cnt <= rise_cnt + 1;
    end
  end

  p_tries_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_cnt <= MAX_TRIES);

  p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_en && $past(phy_en)) |-> $stable({phy_addr_hi, phy_addr_mid, phy_addr_lo, phy_cmd}));

  p_en_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en_run <= EN_WIN + 1);

  p_flag_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    phy_flag_clr |-> $past(phy_reply));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!phy_en && !attempt_start));
endmodule

bind aux_native_engine aux_engine_checker #(
  .EN_WIN(EN_TMO_MS * TICK_DIV), .MAX_TRIES(MAX_TRIES)
) i_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .done(done), .phy_en(phy_en),
  .phy_addr_lo(phy_addr_lo), .phy_addr_mid(phy_addr_mid), .phy_addr_hi(phy_addr_hi),
  .phy_cmd(phy_cmd), .phy_reply(phy_reply), .phy_flag_clr(phy_flag_clr),
  .attempt_start(attempt_start)
);

// File: tb/test_aux_native_engine.sv
module test_aux_native_engine;
  localparam int TDIV = 5, ENMS = 20, RPMS = 10, TRIES = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, cmd_write = 0;
  logic [19:0] cmd_addr = '0;
  logic [7:0] cmd_len = '0;
  logic [127:0] cmd_wdata = '0, phy_rdata = '0;
  logic cmd_ready, done, err, phy_en, phy_flag_clr;
  logic [127:0] rsp_rdata, phy_wdata;
  logic [7:0] phy_addr_lo, phy_addr_mid, phy_cmd;
  logic [3:0] phy_addr_hi;
  logic phy_en_clr = 0, phy_reply = 0, phy_err = 0;
  logic [3:0] phy_status = '0;

  int checks = 0, fails = 0, finished = 0;
  int en_delay = 2, rp_delay = 2, bad_n = 0, drop_en = 0, drop_rp = 0;
  logic [3:0] bad_status = 4'h0; logic bad_err = 0;
  int attempts = 0, clr_cnt = 0, done_cnt = 0;
  logic [7:0] seen_cmd; logic [19:0] seen_addr; logic [127:0] seen_wdata;
  logic got_err; logic [127:0] got_rdata; int got_cycles;

  always #10 clk = ~clk;

  aux_native_engine #(.TICK_DIV(TDIV), .EN_TMO_MS(ENMS), .RPLY_TMO_MS(RPMS),
                      .MAX_TRIES(TRIES), .LEN_W(8)) i_aux_native_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_wdata(cmd_wdata),
    .done(done), .err(err), .rsp_rdata(rsp_rdata), .phy_en(phy_en),
    .phy_addr_lo(phy_addr_lo), .phy_addr_mid(phy_addr_mid), .phy_addr_hi(phy_addr_hi),
    .phy_cmd(phy_cmd), .phy_wdata(phy_wdata), .phy_en_clr(phy_en_clr), .phy_reply(phy_reply),
    .phy_err(phy_err), .phy_status(phy_status), .phy_rdata(phy_rdata), .phy_flag_clr(phy_flag_clr)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int eff(input int n);
    return (n < 1) ? 1 : ((n > 16) ? 16 : n);
  endfunction

  function automatic logic [7:0] want_cmd(input int n, input bit wr);
    return 8'(((eff(n) - 1) * 16) + 8 + (wr ? 0 : 1));
  endfunction

  function automatic logic [127:0] keep_low(input logic [127:0] d, input int n);
    logic [127:0] r = '0;
    for (int b = 0; b < eff(n); b++) r[b*8 +: 8] = d[b*8 +: 8];
    return r;
  endfunction

  // PHY responder
  initial begin
    forever begin
      @(negedge clk);
      if (phy_en) begin
        attempts++;
        seen_cmd = phy_cmd; seen_wdata = phy_wdata;
        seen_addr = {phy_addr_hi, phy_addr_mid, phy_addr_lo};
        if (drop_en == 0) begin
          repeat (en_delay) @(negedge clk);
          phy_en_clr = 1; @(negedge clk); phy_en_clr = 0;
          if (drop_rp == 0) begin
            repeat (rp_delay) @(negedge clk);
            phy_reply = 1;
            phy_status = (attempts <= bad_n) ? bad_status : 4'h0;
            phy_err = (attempts <= bad_n) ? bad_err : 1'b0;
            @(negedge clk);
            phy_reply = 0; phy_status = 4'h0; phy_err = 0;
          end
        end
        while (phy_en) @(negedge clk);
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (phy_flag_clr) clr_cnt++;
    if (done) done_cnt++;
  end

  task automatic cfg(input int ed, input int rd, input int bn, input logic [3:0] bs,
                     input logic be, input int de, input int dr);
    en_delay = ed; rp_delay = rd; bad_n = bn; bad_status = bs; bad_err = be;
    drop_en = de; drop_rp = dr; attempts = 0; clr_cnt = 0; done_cnt = 0;
  endtask

  task automatic run_cmd(input bit wr, input logic [19:0] a, input int n, input logic [127:0] wd);
    @(negedge clk);
    cmd_valid = 1; cmd_write = wr; cmd_addr = a; cmd_len = 8'(n); cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 0;
    got_cycles = 1;
    while (!done && got_cycles < 5000) begin @(negedge clk); got_cycles++; end
    got_err = err; got_rdata = rsp_rdata;
    @(negedge clk);
    chk(!done, "R10 done one cycle", 128'(done), 128'(0));
  endtask

  task automatic t_reset;
    chk(cmd_ready && !done && !phy_en && !err, "R10 reset state",
        128'({cmd_ready, done, phy_en, err}), 128'(4'b1000));
  endtask

  task automatic t_write4;
    logic [127:0] wd = 128'h0F0E0D0C0B0A09080706050403020100 ^ {16{8'h5A}};
    cfg(1, 3, 0, 0, 0, 0, 0);
    run_cmd(1, 20'h5A1C3, 4, wd);
    chk(seen_cmd == want_cmd(4, 1), "R4 write command word", 128'(seen_cmd), 128'(want_cmd(4, 1)));
    chk(seen_addr == 20'h5A1C3, "R3 address fields", 128'(seen_addr), 128'(20'h5A1C3));
    chk(seen_wdata == keep_low(wd, 4), "R5 write payload", seen_wdata, keep_low(wd, 4));
    chk(!got_err && attempts == 1, "R2 single attempt ok", 128'(attempts), 128'(1));
    chk(clr_cnt == 1, "R8 one flag clear", 128'(clr_cnt), 128'(1));
  endtask

  task automatic t_reads;
    for (int i = 0; i < 16; i++) phy_rdata[i*8 +: 8] = 8'(8'hA0 + i);
    cfg(0, 0, 0, 0, 0, 0, 0);
    run_cmd(0, 20'hF0001, 20, '1);
    chk(seen_cmd == want_cmd(20, 0), "R1 clamp above 16", 128'(seen_cmd), 128'(want_cmd(20, 0)));
    chk(got_rdata == phy_rdata, "R6 full read", got_rdata, phy_rdata);
    cfg(4, 1, 0, 0, 0, 0, 0);
    run_cmd(0, 20'h00202, 3, '1);
    chk(got_rdata == keep_low(phy_rdata, 3), "R6 short read upper zero", got_rdata, keep_low(phy_rdata, 3));
    chk(seen_wdata == '0, "R5 buffer cleared on read", seen_wdata, '0);
    cfg(0, 0, 0, 0, 0, 0, 0);
    run_cmd(0, 20'h00100, 0, '0);
    chk(seen_cmd == 8'h09, "R1 zero count becomes one", 128'(seen_cmd), 128'(8'h09));
  endtask

  task automatic t_retry;
    cfg(1, 1, 3, 4'h2, 0, 0, 0);
    run_cmd(1, 20'h12345, 2, 128'hBEEF);
    chk(!got_err && attempts == 4, "R9 status retried then ok", 128'(attempts), 128'(4));
    chk(clr_cnt == 4, "R8 flag clear per reply", 128'(clr_cnt), 128'(4));
    chk(seen_wdata == 128'hBEEF, "R5 payload reloaded on retry", seen_wdata, 128'hBEEF);
    cfg(1, 1, 99, 4'h0, 1, 0, 0);
    run_cmd(1, 20'h12345, 2, 128'hBEEF);
    chk(got_err && attempts == TRIES, "R2 R9 error flag exhausts tries",
        128'({got_err, 8'(attempts)}), 128'({1'b1, 8'(TRIES)}));
  endtask

  task automatic t_timeouts;
    int win;
    cfg(0, 0, 0, 0, 0, 1, 0);
    run_cmd(0, 20'h00300, 1, '0);
    win = TRIES * ENMS * TDIV;
    chk(got_err && attempts == TRIES, "R7 enable timeout retries", 128'(attempts), 128'(TRIES));
    chk(got_cycles >= win && got_cycles <= win + 100, "R7 enable window length",
        128'(got_cycles), 128'(win));
    cfg(0, 0, 0, 0, 0, 0, 1);
    run_cmd(0, 20'h00300, 1, '0);
    chk(got_err && attempts == TRIES, "R7 reply timeout retries", 128'(attempts), 128'(TRIES));
    cfg(ENMS * TDIV - 10, RPMS * TDIV - 10, 0, 0, 0, 0, 0);
    run_cmd(1, 20'h00400, 1, 128'h77);
    chk(!got_err && attempts == 1, "R7 late but in-window ok", 128'(attempts), 128'(1));
  endtask

  task automatic t_busy;
    cfg(30, 2, 0, 0, 0, 0, 0);
    @(negedge clk);
    cmd_valid = 1; cmd_write = 1; cmd_addr = 20'hAAAAA; cmd_len = 1; cmd_wdata = 128'h11;
    @(negedge clk); cmd_valid = 0;
    repeat (5) @(negedge clk);
    chk(!cmd_ready, "R10 ready low while busy", 128'(cmd_ready), 128'(0));
    cmd_valid = 1; cmd_addr = 20'h55555; @(negedge clk); cmd_valid = 0;
    repeat (400) @(negedge clk);
    chk(seen_addr == 20'hAAAAA, "R10 busy command ignored", 128'(seen_addr), 128'(20'hAAAAA));
    chk(done_cnt == 1 && attempts == 1, "R10 single done", 128'(done_cnt), 128'(1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_write4; t_reads; t_retry; t_timeouts; t_busy;
    if (finished == 0) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (finished == 0) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule